// File: doc/BRIEF.md
# Video Pixel Format Widener

The block sits behind a video decoder that presents RGB 8:8:8 pixels on a 16-bit bus. One byte of the bus carries red and holds its value for a whole pixel period of 74 ns. The other byte changes every 37 ns: green in the first half of the period, blue in the second. The block runs on the 27 MHz fast clock. It follows which half of the pixel period is on the bus, stores the first-half byte, and combines it with the slow byte and the second-half byte into one 24-bit pixel. It produces one such pixel per 74 ns, which is the 13.5 MHz pixel rate.

A phase bit marks the two halves of each pixel period. The phase returns to the first half whenever the active-video qualifier is low, so each line starts aligned. Horizontal and vertical sync pass through the same single register stage as the pixel data, so they stay aligned at the output. Outside the active window the pixel output stays at zero and the valid strobe stays low.

Top module: `vid_widen_top`

## Requirements
- R1: While rstN is low, and on the first sample after it is released with inActive low, outRgb is 0, outValid is 0, and outHsync and outVsync are 0.
- R2: The first cycle with inActive high after a cycle with inActive low (or after reset) is the first half of a pixel: inLow is stored on that cycle as the green byte.
- R3: On the second half of a pixel (the active cycle after a first half), the next cycle shows outRgb = {inHigh, stored green, inLow}, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0, all taken from the inputs of the second-half cycle except green.
- R4: outValid is high for exactly one cycle per completed pixel and is never high on two consecutive cycles.
- R5: In any cycle where outValid is low, outRgb is 0. This includes every cycle that follows an inactive input cycle.
- R6: outHsync and outVsync equal inHsync and inVsync delayed by one clock, the same latency as the pixel path.
- R7: An active run of odd length leaves its last first-half byte without a partner, and no pixel is emitted for it.
- R8: If inActive drops in the middle of a pixel and then rises again, the new run starts at the first half, so the stale stored byte is never emitted.
- R9: The value of inHigh during the first half of a pixel has no effect on the output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz fast clock |
| rstN | input | 1 | Active-low synchronous reset |
| inHigh | input | 8 | Slow byte (red), stable across a pixel period |
| inLow | input | 8 | Fast byte: green in the first half, blue in the second half |
| inHsync | input | 1 | Horizontal sync from the decoder |
| inVsync | input | 1 | Vertical sync from the decoder |
| inActive | input | 1 | High during active video samples |
| outRgb | output | 24 | Packed pixel {R, G, B} |
| outHsync | output | 1 | Horizontal sync, delayed to match outRgb |
| outVsync | output | 1 | Vertical sync, delayed to match outRgb |
| outValid | output | 1 | One-cycle strobe for each packed pixel |

## Verification
The assertions assume that inActive is itself the pixel-phase reference. Each active run starts on a first-half sample, and the decoder holds the phase alternation for the length of the run. The decoder can end a run after any number of samples, so the assertions accept odd run lengths and make no claim about where a run ends. The stimulus drives lines of random length, both even and odd, separated by random blanking gaps, with random bytes and sync levels. Directed cases add single-cycle runs, a run broken in the middle of a pixel, and a slow byte that changes between the two halves of a pixel.

// File: rtl/vid_widen_pkg.sv
package vid_widen_pkg;
  // Strobes the control sends to the datapath each fast-clock cycle
  typedef struct packed {
    logic capFirst;   // store the first-half fast byte
    logic emitPixel;  // pack and present a pixel on the next edge
  } widenStrobes_t;
endpackage

// File: rtl/vid_widen_ctrl.sv
module vid_widen_ctrl
  import vid_widen_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inActive,
  output widenStrobes_t strobes
);
  // 0 = first half of the pixel period, 1 = second half
  logic phaseHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseHalf <= 1'b0;
    end else if (!inActive) begin
      phaseHalf <= 1'b0;
    end else begin
      phaseHalf <= ~phaseHalf;
    end
  end

  always_comb begin
    strobes.capFirst  = inActive & ~phaseHalf;
    strobes.emitPixel = inActive &  phaseHalf;
  end
endmodule

// File: rtl/vid_widen_dp.sv
module vid_widen_dp
  import vid_widen_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_W = 2,
  localparam int PIX_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  widenStrobes_t     strobes,
  input  logic [BYTE_W-1:0] inHigh,
  input  logic [BYTE_W-1:0] inLow,
  input  logic [SYNC_W-1:0] inSync,
  output logic [PIX_W-1:0]  outPix,
  output logic [SYNC_W-1:0] outSync,
  output logic              outValid
);
  logic [BYTE_W-1:0] firstByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstByte <= '0;
    end else if (strobes.capFirst) begin
      firstByte <= inLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPix   <= '0;
      outValid <= 1'b0;
    end else if (strobes.emitPixel) begin
      outPix   <= {inHigh, firstByte, inLow};
      outValid <= 1'b1;
    end else begin
      outPix   <= '0;
      outValid <= 1'b0;
    end
  end

  // One register per sync line, matching the single pixel stage
  for (genvar s = 0; s < SYNC_W; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) outSync[s] <= 1'b0;
      else       outSync[s] <= inSync[s];
    end
  end
endmodule

// File: rtl/vid_widen_top.sv
module vid_widen_top
  import vid_widen_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PIX_W = 3 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inHigh,
  input  logic [BYTE_W-1:0] inLow,
  input  logic              inHsync,
  input  logic              inVsync,
  input  logic              inActive,
  output logic [PIX_W-1:0]  outRgb,
  output logic              outHsync,
  output logic              outVsync,
  output logic              outValid
);
  widenStrobes_t strobes;
  logic [1:0]    syncDly;

  vid_widen_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inActive (inActive),
    .strobes  (strobes)
  );

  vid_widen_dp #(.BYTE_W(BYTE_W), .SYNC_W(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inHigh   (inHigh),
    .inLow    (inLow),
    .inSync   ({inVsync, inHsync}),
    .outPix   (outRgb),
    .outSync  (syncDly),
    .outValid (outValid)
  );

  assign outHsync = syncDly[0];
  assign outVsync = syncDly[1];
endmodule

// File: rtl/vid_widen_chk.sv
module vid_widen_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [BYTE_W-1:0] inLow,
  input logic              inHsync,
  input logic              inVsync,
  input logic              inActive,
  input logic [3*BYTE_W-1:0] outRgb,
  input logic              outHsync,
  input logic              outVsync,
  input logic              outValid
);
  AST_VALID_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> outRgb == '0); // R5

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outHsync == $past(inHsync)) && (outVsync == $past(inVsync))); // R6

  AST_PAIR_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inActive, 1) && $past(inActive, 2)); // R3

  AST_BLUE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outRgb[BYTE_W-1:0] == $past(inLow)); // R3

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inActive |=> !outValid); // R5
endmodule

bind vid_widen_top vid_widen_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inLow    (inLow),
  .inHsync  (inHsync),
  .inVsync  (inVsync),
  .inActive (inActive),
  .outRgb   (outRgb),
  .outHsync (outHsync),
  .outVsync (outVsync),
  .outValid (outValid)
);

// File: tb/vid_widen_top_tb_top.sv
`timescale 1ns/1ps
module vid_widen_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inHigh = '0;
  logic [7:0]  inLow = '0;
  logic        inHsync = 1'b0;
  logic        inVsync = 1'b0;
  logic        inActive = 1'b0;
  logic [23:0] outRgb;
  logic        outHsync;
  logic        outVsync;
  logic        outValid;

  int checks = 0;
  int errors = 0;

  // Bench-side model state
  bit       mPhase = 1'b0;
  bit [7:0] mGreen = '0;

  always #2.5 clk = ~clk;

  vid_widen_top dut_i (
    .clk(clk), .rstN(rstN), .inHigh(inHigh), .inLow(inLow),
    .inHsync(inHsync), .inVsync(inVsync), .inActive(inActive),
    .outRgb(outRgb), .outHsync(outHsync), .outVsync(outVsync),
    .outValid(outValid)
  );

  task automatic checkEq(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [24:0] predict(bit [7:0] hi, bit [7:0] lo, bit act);
    bit [24:0] r;
    r = '0;
    if (!act) begin
      mPhase = 1'b0;
    end else if (!mPhase) begin
      mGreen = lo;
      mPhase = 1'b1;
    end else begin
      r = {1'b1, hi, mGreen, lo};
      mPhase = 1'b0;
    end
    return r;
  endfunction

  // Drive at a falling edge, check at the next falling edge
  task automatic step(string tag, bit [7:0] hi, bit [7:0] lo, bit hs, bit vs, bit act);
    bit [24:0] e;
    inHigh = hi; inLow = lo; inHsync = hs; inVsync = vs; inActive = act;
    e = predict(hi, lo, act);
    @(negedge clk);
    checkEq({tag, " R4 valid"}, {23'd0, outValid}, {23'd0, e[24]});
    checkEq(e[24] ? {tag, " R3 pixel"} : {tag, " R5 idle"}, outRgb, e[23:0]);
    checkEq("R6 sync", {22'd0, outVsync, outHsync}, {22'd0, vs, hs});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    @(negedge clk);
    @(negedge clk);
    checkEq("R1 reset rgb", outRgb, 24'd0);
    checkEq("R1 reset ctl", {21'd0, outValid, outHsync, outVsync}, 24'd0);
    rstN = 1'b1;
    step("R1", 8'h00, 8'h00, 0, 0, 0);

    // R2 / R3: a simple two-pixel run
    step("R2", 8'hA1, 8'h11, 0, 0, 1);
    step("R3", 8'hA1, 8'h22, 0, 0, 1);
    step("R2", 8'hB2, 8'h33, 0, 0, 1);
    step("R3", 8'hB2, 8'h44, 0, 0, 1);
    step("R5", 8'hFF, 8'hFF, 1, 0, 0);
    // R7: single-sample run emits nothing
    step("R7", 8'hC3, 8'h55, 0, 0, 1);
    step("R7", 8'hC3, 8'h66, 0, 1, 0);
    // R8: break mid-pixel, restart at first half
    step("R8", 8'hD4, 8'h77, 0, 0, 1);
    step("R8", 8'h00, 8'h00, 0, 0, 0);
    step("R8", 8'hE5, 8'h88, 0, 0, 1);
    step("R8", 8'hE5, 8'h99, 0, 0, 1);
    // R9: slow byte differs in the first half
    step("R9", 8'h12, 8'hAA, 0, 0, 1);
    step("R9", 8'h34, 8'hBB, 0, 0, 1);
    step("R5", 8'h00, 8'h00, 0, 0, 0);

    // Random lines with random blanking
    for (int line = 0; line < 120; line++) begin
      int len;
      int gap;
      len = 1 + int'($urandom % 40);
      gap = 1 + int'($urandom % 6);
      for (int i = 0; i < len; i++) begin
        step("R3", 8'($urandom), 8'($urandom), 0, 0, 1);
      end
      for (int g = 0; g < gap; g++) begin
        step("R5", 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 0);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule